// File: doc/BRIEF.md
# Parity-Checked Memory with Per-Word Write Lock

This block sits in front of a word-addressed store. Each location holds a 16-bit data word, a parity bit and a write-lock bit. On every write the block computes odd parity over the data word and the lock bit together. On every read it checks that parity. A processor port reads and writes the store. A write on this port to a locked word is refused and flagged.

An interval-timer port may overwrite any word, locked or not, and never raises a flag. Lock bits change only through a lock-update command, and only while an unlock input is held high.

Two error conditions are reported as sticky bits of a 16-bit internal-interrupt status word: a parity failure and a lock violation. Any set bit drives an interrupt request. Software clears the bits with a pulse on a clear input. For diagnostics, a processor write can ask for its parity bit to be inverted, so that the check path can be exercised.

Top module: `gmem_guard`

## Requirements
- R1: A processor read presented in cycle T returns the stored data word on `cpu_rdata`, with `cpu_rvalid` high, in cycle T+1. A processor write to an unlocked word replaces the data word.
- R2: Stored parity makes the total count of ones over the data word, the parity bit and the lock bit odd. A read of any word written normally, locked or unlocked, and including all-zero and all-one data, reports no parity failure.
- R3: A read whose stored word has even total parity sets bit 2 of `int_status` in the cycle after `cpu_rvalid`, and `int_req` rises with it. The returned data is still delivered.
- R4: A processor write to a locked word leaves the word unchanged. It asserts `cpu_viol` in the same cycle as the request, sets bit 3 of `int_status` on the next clock edge, and raises `int_req`.
- R5: A timer-port write replaces the data word of a location whether or not it is locked. It never asserts `cpu_viol` and keeps correct parity.
- R6: A lock-update command changes a word's lock bit only while `unlock` is high. With `unlock` low the command has no effect on any lock bit.
- R7: A lock update leaves the data word unchanged and keeps the word's parity state. A good word stays good, and a word stored with bad parity still fails its next read.
- R8: Only the low log2(DEPTH) address bits select a location, so the address space is circular: address DEPTH aliases address 0, and address 0x7FFF aliases DEPTH-1.
- R9: Status bits 2 and 3 stay set until `err_clr` is pulsed. When a new error and `err_clr` arrive in the same cycle, the error bit ends up set. All other `int_status` bits read 0.
- R10: After reset, `int_status` is 0, `int_req` is 0 and `cpu_rvalid` is 0, and every lock bit is 0.
- R11: Only one write is applied per cycle, with priority timer write, then lock update, then processor write. A processor write that loses arbitration is dropped without a violation, and so is a lock update that loses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_par_flip | input | 1 | Store inverted parity on this processor write (diagnostic) |
| cpu_rdata | output | 16 | Read data |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_viol | output | 1 | Lock violation on the current processor write |
| tmr_we | input | 1 | Timer-port write strobe |
| tmr_addr | input | 15 | Timer-port word address |
| tmr_wdata | input | 16 | Timer-port write data |
| lock_cmd | input | 1 | Lock-update command |
| lock_addr | input | 15 | Lock-update address |
| lock_val | input | 1 | New lock value |
| unlock | input | 1 | Enables lock updates |
| err_clr | input | 1 | Clears the sticky status bits |
| int_status | output | 16 | Internal-interrupt status word (bit 2 parity, bit 3 violation) |
| int_req | output | 1 | Internal interrupt request |

## Verification
Checked on every cycle:
- a violation is always followed by status bit 3;
- a parity failure is always followed by status bit 2 and the request;
- the error bits hold until a clear;
- a timer write never flags;
- lock bits stay put when a command arrives without `unlock`;
- read requests and valid data pair one-to-one.

Only the bench scenarios can show:
- that data actually lands in the store or is held back;
- that parity survives lock changes in both good and bad states;
- that addresses alias;
- which write wins under contention.

// File: rtl/gmem_pkg.sv
package gmem_pkg;
  localparam int DATA_W      = 16;
  localparam int STAT_W      = 16;
  localparam int ST_PAR_IDX  = 2;
  localparam int ST_LOCK_IDX = 3;

  typedef struct packed {
    logic              lock;
    logic              par;
    logic [DATA_W-1:0] data;
  } gword_t;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_TIMER = 2'd1,
    WR_LOCK  = 2'd2,
    WR_CPU   = 2'd3
  } wsrc_e;

  // parity bit that makes {lock, data, parity} hold an odd count of ones
  function automatic logic odd_fill(input logic lock, input logic [DATA_W-1:0] d);
    return ~(^{lock, d});
  endfunction
endpackage

// File: rtl/gmem_arb.sv
module gmem_arb
  import gmem_pkg::*;
#(
  parameter int LOC_W = 8
) (
  input  logic              tmr_we,
  input  logic [LOC_W-1:0]  tmr_loc,
  input  logic [DATA_W-1:0] tmr_data,
  input  logic              tmr_lock,
  input  logic              lock_cmd,
  input  logic              unlock,
  input  logic [LOC_W-1:0]  lock_loc,
  input  logic              lock_val,
  input  logic              cpu_wr,
  input  logic [LOC_W-1:0]  cpu_loc,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_flip,
  input  logic              cpu_lock,
  output wsrc_e             wsrc,
  output logic [LOC_W-1:0]  wr_loc,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_par,
  output logic              viol
);
  always_comb begin
    wsrc    = WR_NONE;
    wr_loc  = cpu_loc;
    wr_data = cpu_data;
    wr_par  = 1'b0;
    viol    = 1'b0;
    if (tmr_we) begin
      wsrc    = WR_TIMER;
      wr_loc  = tmr_loc;
      wr_data = tmr_data;
      wr_par  = odd_fill(tmr_lock, tmr_data);
    end else if (lock_cmd && unlock) begin
      wsrc    = WR_LOCK;
      wr_loc  = lock_loc;
      wr_par  = lock_val;
    end else if (cpu_wr) begin
      if (cpu_lock) begin
        viol = 1'b1;
      end else begin
        wsrc   = WR_CPU;
        wr_par = odd_fill(1'b0, cpu_data) ^ cpu_flip;
      end
    end
  end
endmodule

// File: rtl/gmem_store.sv
module gmem_store
  import gmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  wsrc_e             wsrc,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              rd_en,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [DEPTH-1:0]  lock_bits,
  output gword_t            rd_word,
  output logic              rd_valid
);
  logic [DATA_W-1:0] dat_mem [DEPTH];
  logic              par_mem [DEPTH];
  logic [DEPTH-1:0]  lock_d, lock_q;
  logic              data_we, lock_we;

  assign data_we = (wsrc == WR_TIMER) || (wsrc == WR_CPU);
  assign lock_we = (wsrc == WR_LOCK);

  always_comb begin
    lock_d = lock_q;
    if (lock_we) lock_d[wr_loc] = wr_par;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) lock_q <= '0;
    else         lock_q <= lock_d;
  end

  // data and parity array, no reset; a lock change flips parity only if the bit changes
  always_ff @(posedge clk) begin
    if (data_we) begin
      dat_mem[wr_loc] <= wr_data;
      par_mem[wr_loc] <= wr_par;
    end else if (lock_we) begin
      par_mem[wr_loc] <= par_mem[wr_loc] ^ (lock_q[wr_loc] ^ wr_par);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= '{lock: lock_q[rd_loc], par: par_mem[rd_loc], data: dat_mem[rd_loc]};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rd_valid <= 1'b0;
    else         rd_valid <= rd_en;
  end

  assign lock_bits = lock_q;
endmodule

// File: rtl/gmem_status.sv
module gmem_status
  import gmem_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              par_fail,
  input  logic              viol,
  input  logic              clr,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic par_q, par_d, lock_q, lock_d;

  always_comb begin
    par_d  = clr ? 1'b0 : par_q;
    lock_d = clr ? 1'b0 : lock_q;
    if (par_fail) par_d  = 1'b1;
    if (viol)     lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      par_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      par_q  <= par_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_PAR_IDX]  = par_q;
    status[ST_LOCK_IDX] = lock_q;
  end
  assign irq = par_q | lock_q;
endmodule

// File: rtl/gmem_guard.sv
module gmem_guard
  import gmem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_par_flip,
  output logic [15:0]       cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_viol,
  input  logic              tmr_we,
  input  logic [ADDR_W-1:0] tmr_addr,
  input  logic [15:0]       tmr_wdata,
  input  logic              lock_cmd,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              lock_val,
  input  logic              unlock,
  input  logic              err_clr,
  output logic [15:0]       int_status,
  output logic              int_req
);
  localparam int LOC_W = $clog2(DEPTH);

  logic [1:0]       rst_sync;
  logic             arst_n;
  logic [LOC_W-1:0] cpu_loc, tmr_loc, lck_loc;
  logic [DEPTH-1:0] lock_bits;
  wsrc_e            wsrc;
  logic [LOC_W-1:0] wr_loc;
  logic [DATA_W-1:0] wr_data;
  logic             wr_par;
  logic             viol;
  logic             rd_en;
  gword_t           rd_word;
  logic             rd_valid;
  logic             par_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  // circular addressing: upper address bits do not select
  assign cpu_loc = cpu_addr[LOC_W-1:0];
  assign tmr_loc = tmr_addr[LOC_W-1:0];
  assign lck_loc = lock_addr[LOC_W-1:0];

  generate
    if (LOC_W < ADDR_W) begin : g_alias
      logic addr_hi_unused;
      assign addr_hi_unused = ^{cpu_addr[ADDR_W-1:LOC_W], tmr_addr[ADDR_W-1:LOC_W],
                                lock_addr[ADDR_W-1:LOC_W]};
    end
  endgenerate

  gmem_arb #(.LOC_W(LOC_W)) u_arb (
    .tmr_we   (tmr_we),
    .tmr_loc  (tmr_loc),
    .tmr_data (tmr_wdata),
    .tmr_lock (lock_bits[tmr_loc]),
    .lock_cmd (lock_cmd),
    .unlock   (unlock),
    .lock_loc (lck_loc),
    .lock_val (lock_val),
    .cpu_wr   (cpu_req && cpu_we),
    .cpu_loc  (cpu_loc),
    .cpu_data (cpu_wdata),
    .cpu_flip (cpu_par_flip),
    .cpu_lock (lock_bits[cpu_loc]),
    .wsrc     (wsrc),
    .wr_loc   (wr_loc),
    .wr_data  (wr_data),
    .wr_par   (wr_par),
    .viol     (viol)
  );

  assign rd_en = cpu_req && !cpu_we;

  gmem_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .arst_n    (arst_n),
    .wsrc      (wsrc),
    .wr_loc    (wr_loc),
    .wr_data   (wr_data),
    .wr_par    (wr_par),
    .rd_en     (rd_en),
    .rd_loc    (cpu_loc),
    .lock_bits (lock_bits),
    .rd_word   (rd_word),
    .rd_valid  (rd_valid)
  );

  assign par_fail = rd_valid && !(^rd_word);

  gmem_status u_stat (
    .clk      (clk),
    .arst_n   (arst_n),
    .par_fail (par_fail),
    .viol     (viol),
    .clr      (err_clr),
    .status   (int_status),
    .irq      (int_req)
  );

  assign cpu_rdata  = rd_word.data;
  assign cpu_rvalid = rd_valid;
  assign cpu_viol   = viol;
endmodule

// File: rtl/gmem_guard_chk.sv
module gmem_guard_chk #(
  parameter int DEPTH = 256
) (
  input logic             clk,
  input logic             arst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             tmr_we,
  input logic             lock_cmd,
  input logic             unlock,
  input logic             err_clr,
  input logic             cpu_viol,
  input logic             cpu_rvalid,
  input logic             par_fail,
  input logic [15:0]      int_status,
  input logic             int_req,
  input logic [DEPTH-1:0] lock_bits
);
  p_rd_answer_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_req && !cpu_we) |=> cpu_rvalid);
  p_rd_origin_r1: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_rvalid |-> $past(cpu_req && !cpu_we));
  p_par_flag_r3: assert property (@(posedge clk) disable iff (!arst_n)
    par_fail |=> (int_status[2] && int_req));
  p_viol_flag_r4: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_viol |=> (int_status[3] && int_req));
  p_viol_src_r4: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_viol |-> (cpu_req && cpu_we));
  p_tmr_quiet_r5: assert property (@(posedge clk) disable iff (!arst_n)
    tmr_we |-> !cpu_viol);
  p_lock_held_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (lock_cmd && !unlock) |=> $stable(lock_bits));
  p_sticky_par_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (int_status[2] && !err_clr) |=> int_status[2]);
  p_sticky_lock_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (int_status[3] && !err_clr) |=> int_status[3]);
endmodule

bind gmem_guard gmem_guard_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .tmr_we     (tmr_we),
  .lock_cmd   (lock_cmd),
  .unlock     (unlock),
  .err_clr    (err_clr),
  .cpu_viol   (cpu_viol),
  .cpu_rvalid (cpu_rvalid),
  .par_fail   (par_fail),
  .int_status (int_status),
  .int_req    (int_req),
  .lock_bits  (lock_bits)
);

// File: tb/gmem_guard_tb.sv
module gmem_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, cpu_par_flip = 0;
  logic [14:0] cpu_addr = '0, tmr_addr = '0, lock_addr = '0;
  logic [15:0] cpu_wdata = '0, tmr_wdata = '0;
  logic        tmr_we = 0, lock_cmd = 0, lock_val = 0, unlock = 0, err_clr = 0;
  logic [15:0] cpu_rdata, int_status;
  logic        cpu_rvalid, cpu_viol, int_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gmem_guard u_dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_par_flip = 0; tmr_we = 0;
    lock_cmd = 0; lock_val = 0; unlock = 0; err_clr = 0;
  endtask

  task automatic cpu_write(logic [14:0] a, logic [15:0] d, logic flip, logic clr,
                           logic exp_viol, string tag);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_par_flip = flip; err_clr = clr;
    #1 chk(tag, {15'd0, cpu_viol}, {15'd0, exp_viol});
    step();
  endtask

  task automatic cpu_read(logic [14:0] a, logic [15:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    step();
  endtask

  task automatic tmr_write(logic [14:0] a, logic [15:0] d);
    tmr_we = 1; tmr_addr = a; tmr_wdata = d;
    #1 chk("R5 timer no viol", {15'd0, cpu_viol}, 16'd0);
    step();
  endtask

  task automatic lock_set(logic [14:0] a, logic v, logic unl);
    lock_cmd = 1; lock_addr = a; lock_val = v; unlock = unl;
    step();
  endtask

  task automatic clear();
    err_clr = 1;
    step();
  endtask

  // monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read actual=%h expected=none", cpu_rdata);
      end else begin
        chk(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 status at reset", int_status, 16'h0000);
    chk("R10 irq at reset", {15'd0, int_req}, 16'd0);
    chk("R10 rvalid at reset", {15'd0, cpu_rvalid}, 16'd0);

    // R10 lock bits clear: write accepted without violation
    cpu_write(15'h0005, 16'h5A5A, 0, 0, 0, "R10 unlocked at reset");
    cpu_read(15'h0005, 16'h5A5A, "R10 read back");

    // R1 / R2 patterns
    cpu_write(15'h0010, 16'hA5A5, 0, 0, 0, "R1 write");
    cpu_write(15'h0011, 16'h0000, 0, 0, 0, "R1 write zero");
    cpu_write(15'h0012, 16'hFFFF, 0, 0, 0, "R1 write ones");
    cpu_write(15'h0013, 16'h0001, 0, 0, 0, "R1 write one");
    cpu_read(15'h0010, 16'hA5A5, "R1 read A5A5");
    cpu_read(15'h0011, 16'h0000, "R2 read zero");
    cpu_read(15'h0012, 16'hFFFF, "R2 read ones");
    cpu_read(15'h0013, 16'h0001, "R1 read one");
    step();
    chk("R2 no parity error", int_status, 16'h0000);

    // R8 circular addressing
    cpu_write(15'h0100, 16'h1234, 0, 0, 0, "R8 write alias");
    cpu_read(15'h0000, 16'h1234, "R8 DEPTH aliases 0");
    cpu_write(15'h7FFF, 16'h4321, 0, 0, 0, "R8 write top");
    cpu_read(15'h00FF, 16'h4321, "R8 7FFF aliases FF");

    // R6 lock command without unlock is ignored
    lock_set(15'h0020, 1, 0);
    cpu_write(15'h0020, 16'hBBBB, 0, 0, 0, "R6 locked without unlock");
    cpu_read(15'h0020, 16'hBBBB, "R6 write landed");

    // R4 violation
    lock_set(15'h0020, 1, 1);
    cpu_write(15'h0020, 16'hCCCC, 0, 0, 1, "R4 viol same cycle");
    chk("R4 status bit3", int_status, 16'h0008);
    chk("R4 irq", {15'd0, int_req}, 16'd1);
    cpu_read(15'h0020, 16'hBBBB, "R4 word unchanged");
    repeat (3) step();
    chk("R9 sticky", int_status, 16'h0008);
    clear();
    chk("R9 cleared", int_status, 16'h0000);
    chk("R9 irq cleared", {15'd0, int_req}, 16'd0);

    // R7 locked read good parity, R5 timer write to locked word
    cpu_read(15'h0020, 16'hBBBB, "R7 locked read");
    tmr_write(15'h0020, 16'hDDDD);
    cpu_read(15'h0020, 16'hDDDD, "R5 timer write landed");
    step();
    chk("R2 locked word parity ok", int_status, 16'h0000);

    // unlock word, then writable
    lock_set(15'h0020, 0, 1);
    cpu_write(15'h0020, 16'hEEEE, 0, 0, 0, "R6 unlock took effect");
    cpu_read(15'h0020, 16'hEEEE, "R6 read after unlock");
    step();
    chk("R7 parity after unlock", int_status, 16'h0000);

    // R3 parity failure
    cpu_write(15'h0030, 16'h00F0, 1, 0, 0, "R3 diag write");
    cpu_read(15'h0030, 16'h00F0, "R3 data still delivered");
    chk("R3 not yet flagged", int_status, 16'h0000);
    step();
    chk("R3 status bit2", int_status, 16'h0004);
    chk("R3 irq", {15'd0, int_req}, 16'd1);
    clear();

    // R7 lock change keeps bad parity
    lock_set(15'h0030, 1, 1);
    cpu_read(15'h0030, 16'h00F0, "R7 data kept");
    step();
    chk("R7 bad parity kept", int_status, 16'h0004);
    clear();
    chk("R9 clear bit2", int_status, 16'h0000);

    // R9 set wins over clear
    cpu_write(15'h0030, 16'h1111, 0, 1, 1, "R9 viol with clear");
    chk("R9 set wins", int_status, 16'h0008);
    clear();

    // R11 arbitration
    cpu_write(15'h0041, 16'h1111, 0, 0, 0, "R11 setup");
    tmr_we = 1; tmr_addr = 15'h0040; tmr_wdata = 16'h2222;
    cpu_req = 1; cpu_we = 1; cpu_addr = 15'h0041; cpu_wdata = 16'h3333;
    #1 chk("R11 dropped write no viol", {15'd0, cpu_viol}, 16'd0);
    step();
    cpu_read(15'h0040, 16'h2222, "R11 timer won");
    cpu_read(15'h0041, 16'h1111, "R11 cpu write dropped");
    tmr_we = 1; tmr_addr = 15'h0050; tmr_wdata = 16'h7777;
    lock_cmd = 1; lock_addr = 15'h0051; lock_val = 1; unlock = 1;
    step();
    cpu_write(15'h0051, 16'h8888, 0, 0, 0, "R11 lock update dropped");
    cpu_read(15'h0051, 16'h8888, "R11 read 51");
    cpu_read(15'h0050, 16'h7777, "R11 read 50");
    repeat (3) step();
    chk("R2 final status", int_status, 16'h0000);
    chk("R1 all reads returned", 16'(exp_q.size()), 16'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule